// File: doc/BRIEF.md
# Privileged Handler Entry Sequencer

This block turns an accepted exception into a jump to a privileged handler. Each cycle it may accept one exception, given as a code, a call-gate function number, the PC to return to and the handler base address. It works out an entry offset, adds it to the base, and records the return address with the current privileged-mode flag folded into bit 0. It then places the processor in privileged mode. Fixed exception causes use a table of evenly spaced vectors. Call-gate traps use one of two regions, privileged or unprivileged, with 64 entries of 64 bytes each.

The first entry into privileged mode exchanges eight architectural integer registers with a private bank of eight shadow registers. The exchange happens in one clock edge over a dedicated port to the register file. The lanes of that port map, in order 0 to 7, to integer registers 8, 9, 10, 11, 12, 13, 14 and 25. An entry taken while already privileged redirects the PC but leaves both banks alone. A pulse on the leave input returns the block to unprivileged mode. An exception code the block does not recognise raises a fault pulse and changes nothing else.

Top module: `exc_entry_seq`

## Requirements
- R1: After a synchronous reset, redirect, exc_fault, exc_clear, swap_we and priv_mode are 0, new_pc and exc_addr are 0, and every shadow lane holds 0.
- R2: For codes 0 to 9 (reset, machine check, interprocessor, clock, device, memory fault, unaligned, illegal opcode, arithmetic, FP disabled), new_pc becomes hbase + code*0x80 on the cycle after exc_valid, with redirect high for that one cycle.
- R3: For code 10 (call gate) with exc_fn[7]=0 and exc_fn[6]=0, new_pc becomes hbase + 0x1000 + exc_fn[5:0]*64.
- R4: For code 10 with exc_fn[7]=1 and exc_fn[6]=0, new_pc becomes hbase + 0x2000 + exc_fn[5:0]*64.
- R5: A call gate with exc_fn[6]=1 lies outside both 64-entry regions. It gives an exc_fault pulse and no redirect.
- R6: On a redirect, exc_addr equals cur_pc bitwise-ORed with the privileged-mode flag, as it stood when the exception was accepted, in bit 0.
- R7: On the cycle of every redirect, priv_mode reads 1.
- R8: An entry from unprivileged mode raises swap_we in the redirect cycle, with swap_wdata carrying the old shadow bank. At that same edge the shadow bank captures arch_rd, so the next swap returns those values.
- R9: An entry taken while already privileged keeps swap_we low and leaves the shadow bank unchanged.
- R10: Codes 11 to 15 give an exc_fault pulse with no redirect, and new_pc, exc_addr and priv_mode keep their values.
- R11: exc_clear pulses for exactly one cycle on the cycle after each exc_valid, together with either redirect or exc_fault, never both. It stays low otherwise.
- R12: leave_priv clears priv_mode on the next cycle. It is ignored in a cycle where exc_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception accepted this cycle |
| exc_code | input | 4 | Exception cause code |
| exc_fn | input | 8 | Call-gate function number |
| cur_pc | input | 64 | Return PC of the excepting instruction |
| hbase | input | 64 | Handler base address |
| leave_priv | input | 1 | Return to unprivileged mode |
| arch_rd | input | 512 | Current values of the eight swapped integer registers, lane i at bits 64*i+63:64*i |
| redirect | output | 1 | new_pc is valid this cycle |
| exc_fault | output | 1 | Unrecognised exception, nothing changed |
| exc_clear | output | 1 | Pending exception retired |
| new_pc | output | 64 | Handler entry address |
| exc_addr | output | 64 | Saved return address with mode in bit 0 |
| priv_mode | output | 1 | Privileged-mode flag |
| swap_we | output | 1 | Write swap_wdata into the eight integer registers |
| swap_wdata | output | 512 | Old shadow values, same lane order as arch_rd |

## Verification
The hardest case to reach is proving that the shadow bank truly captured the register values, since the bank is only visible when a later swap writes it back. The bench holds a small register-file model that drives arch_rd and applies swap_we. It enters privileged mode once, which writes the reset shadow contents into the registers. It then leaves and enters again, and expects the original register values back on swap_wdata. A nested entry between those two steps, taken while already privileged, shows that no exchange disturbs that round trip.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W      = 4;
  localparam int FN_W        = 8;
  localparam int GATE_IDX_W  = 6;
  localparam int NUM_FIXED   = 10;
  localparam int VEC_SHIFT   = 7;
  localparam int GATE_SHIFT  = 6;
  localparam int PRIV_GATE   = 'h1000;
  localparam int UNPRIV_GATE = 'h2000;
  localparam int OFF_W       = 14;
  localparam logic [CODE_W-1:0] CODE_GATE = 4'd10;
endpackage

// File: rtl/entry_offset.sv
module entry_offset
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [FN_W-1:0]   fn,
  output logic [OFF_W-1:0]  offset,
  output logic              known
);
  localparam int FIX_LIM = NUM_FIXED;

  always_comb begin
    offset = '0;
    known  = 1'b0;
    if (int'(code) < FIX_LIM) begin
      offset = OFF_W'(code) << VEC_SHIFT;
      known  = 1'b1;
    end else if (code == CODE_GATE && !fn[GATE_IDX_W]) begin
      offset = (fn[FN_W-1] ? OFF_W'(UNPRIV_GATE) : OFF_W'(PRIV_GATE))
             + (OFF_W'(fn[GATE_IDX_W-1:0]) << GATE_SHIFT);
      known  = 1'b1;
    end
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int XLEN = 64,
  parameter int NREG = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 swap_go,
  input  logic [NREG*XLEN-1:0] arch_rd,
  output logic [NREG*XLEN-1:0] bank_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        bank_q[g*XLEN +: XLEN] <= '0;
      else if (swap_go)
        bank_q[g*XLEN +: XLEN] <= arch_rd[g*XLEN +: XLEN];
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 exc_valid,
  input  logic [CODE_W-1:0]    exc_code,
  input  logic [FN_W-1:0]      exc_fn,
  input  logic [XLEN-1:0]      cur_pc,
  input  logic [XLEN-1:0]      hbase,
  input  logic                 leave_priv,
  input  logic [NREG*XLEN-1:0] arch_rd,
  output logic                 redirect,
  output logic                 exc_fault,
  output logic                 exc_clear,
  output logic [XLEN-1:0]      new_pc,
  output logic [XLEN-1:0]      exc_addr,
  output logic                 priv_mode,
  output logic                 swap_we,
  output logic [NREG*XLEN-1:0] swap_wdata
);
  logic [OFF_W-1:0] off;
  logic             known;
  logic             take;
  logic             redirect_q, fault_q, clear_q, swap_q, priv_q;
  logic [XLEN-1:0]  pc_q, addr_q;

  entry_offset u_off (
    .code   (exc_code),
    .fn     (exc_fn),
    .offset (off),
    .known  (known)
  );

  assign take = exc_valid && known;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_q <= 1'b0;
      fault_q    <= 1'b0;
      clear_q    <= 1'b0;
      swap_q     <= 1'b0;
      priv_q     <= 1'b0;
      pc_q       <= '0;
      addr_q     <= '0;
    end else begin
      redirect_q <= take;
      fault_q    <= exc_valid && !known;
      clear_q    <= exc_valid;
      swap_q     <= take && !priv_q;
      if (take) begin
        pc_q   <= hbase + XLEN'(off);
        addr_q <= cur_pc | XLEN'(priv_q);
        priv_q <= 1'b1;
      end else if (!exc_valid && leave_priv) begin
        priv_q <= 1'b0;
      end
    end
  end

  shadow_bank #(.XLEN(XLEN), .NREG(NREG)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .swap_go (swap_q),
    .arch_rd (arch_rd),
    .bank_q  (swap_wdata)
  );

  assign redirect  = redirect_q;
  assign exc_fault = fault_q;
  assign exc_clear = clear_q;
  assign new_pc    = pc_q;
  assign exc_addr  = addr_q;
  assign priv_mode = priv_q;
  assign swap_we   = swap_q;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            redirect,
  input logic            exc_fault,
  input logic            exc_clear,
  input logic            priv_mode,
  input logic            swap_we,
  input logic [XLEN-1:0] new_pc,
  input logic [XLEN-1:0] exc_addr,
  input logic [XLEN-1:0] cur_pc
);
  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    !(redirect && exc_fault));
  // R11
  clear_pair_chk: assert property (@(posedge clk) disable iff (rst)
    exc_clear |-> (redirect || exc_fault));
  // R7
  mode_set_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> priv_mode);
  // R8
  swap_entry_chk: assert property (@(posedge clk) disable iff (rst)
    swap_we |-> (redirect && !$past(priv_mode)));
  // R9
  no_nested_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect && $past(priv_mode)) |-> !swap_we);
  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    exc_fault |-> ($stable(new_pc) && $stable(exc_addr) && $stable(priv_mode)));
  // R6
  mode_bit_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (exc_addr[0] == ($past(priv_mode) | $past(cur_pc[0]))));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .redirect  (redirect),
  .exc_fault (exc_fault),
  .exc_clear (exc_clear),
  .priv_mode (priv_mode),
  .swap_we   (swap_we),
  .new_pc    (new_pc),
  .exc_addr  (exc_addr),
  .cur_pc    (cur_pc)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int XLEN = 64;
  localparam int NREG = 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 exc_valid = 1'b0;
  logic [3:0]           exc_code = '0;
  logic [7:0]           exc_fn = '0;
  logic [XLEN-1:0]      cur_pc = '0;
  logic [XLEN-1:0]      hbase = '0;
  logic                 leave_priv = 1'b0;
  logic [NREG*XLEN-1:0] arch_rd;
  logic                 redirect, exc_fault, exc_clear, priv_mode, swap_we;
  logic [XLEN-1:0]      new_pc, exc_addr;
  logic [NREG*XLEN-1:0] swap_wdata;

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] init_val [NREG];
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  exc_entry_seq #(.XLEN(XLEN), .NREG(NREG)) i_exc_entry_seq (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_fn(exc_fn), .cur_pc(cur_pc), .hbase(hbase), .leave_priv(leave_priv),
    .arch_rd(arch_rd), .redirect(redirect), .exc_fault(exc_fault),
    .exc_clear(exc_clear), .new_pc(new_pc), .exc_addr(exc_addr),
    .priv_mode(priv_mode), .swap_we(swap_we), .swap_wdata(swap_wdata)
  );

  // register-file model on the swap port
  always_comb
    for (int i = 0; i < NREG; i++) arch_rd[i*XLEN +: XLEN] = regs[i];

  always @(posedge clk)
    if (swap_we)
      for (int i = 0; i < NREG; i++) regs[i] <= swap_wdata[i*XLEN +: XLEN];

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] c, input logic [7:0] f,
                      input logic [XLEN-1:0] pc, input logic lv);
    exc_valid = 1'b1; exc_code = c; exc_fn = f; cur_pc = pc; leave_priv = lv;
    @(negedge clk);
    exc_valid = 1'b0; leave_priv = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 redirect", {63'd0, redirect}, 0);
    chk("R1 fault", {63'd0, exc_fault}, 0);
    chk("R1 clear", {63'd0, exc_clear}, 0);
    chk("R1 swap_we", {63'd0, swap_we}, 0);
    chk("R1 priv", {63'd0, priv_mode}, 0);
    chk("R1 new_pc", new_pc, 0);
    chk("R1 exc_addr", exc_addr, 0);
  endtask

  task automatic t_first_entry;
    hbase = 64'h0000_0000_0080_0000;
    fire(4'd5, 8'h00, 64'h0000_1234_0000_0041, 1'b0);
    chk("R2 new_pc code5", new_pc, hbase + 64'h280);
    chk("R6 exc_addr unpriv", exc_addr, 64'h0000_1234_0000_0041);
    chk("R7 priv set", {63'd0, priv_mode}, 1);
    chk("R8 swap_we", {63'd0, swap_we}, 1);
    chk("R11 clear", {63'd0, exc_clear}, 1);
    for (int i = 0; i < NREG; i++)
      chk("R1 R8 shadow reset lane", swap_wdata[i*XLEN +: XLEN], 0);
    @(negedge clk);
    chk("R8 swap_we one cycle", {63'd0, swap_we}, 0);
    chk("R11 clear one cycle", {63'd0, exc_clear}, 0);
    for (int i = 0; i < NREG; i++)
      chk("R8 regs got shadow", regs[i], 0);
  endtask

  task automatic t_fixed;
    for (int k = 0; k < 10; k++) begin
      fire(4'(k), 8'hFF, 64'h2000 + 64'(k*16), 1'b0);
      chk("R2 fixed vector", new_pc, hbase + 64'(k*128));
      chk("R6 exc_addr priv bit", exc_addr, (64'h2000 + 64'(k*16)) | 64'd1);
      chk("R9 no swap nested", {63'd0, swap_we}, 0);
      chk("R11 redirect", {63'd0, redirect}, 1);
    end
  endtask

  task automatic t_gate;
    fire(4'd10, 8'h00, 64'h3000, 1'b0);
    chk("R3 priv gate 0", new_pc, hbase + 64'h1000);
    fire(4'd10, 8'h3F, 64'h3000, 1'b0);
    chk("R3 priv gate 63", new_pc, hbase + 64'h1000 + 64'd63*64);
    fire(4'd10, 8'h80, 64'h3000, 1'b0);
    chk("R4 unpriv gate 0", new_pc, hbase + 64'h2000);
    fire(4'd10, 8'h85, 64'h3000, 1'b0);
    chk("R4 unpriv gate 5", new_pc, hbase + 64'h2000 + 64'd320);
    fire(4'd10, 8'hBF, 64'h3000, 1'b0);
    chk("R4 unpriv gate 63", new_pc, hbase + 64'h2000 + 64'd63*64);
  endtask

  task automatic t_faults;
    logic [XLEN-1:0] pc0, a0;
    pc0 = new_pc; a0 = exc_addr;
    fire(4'd10, 8'h40, 64'h9990, 1'b0);
    chk("R5 fault fn6", {63'd0, exc_fault}, 1);
    chk("R5 no redirect", {63'd0, redirect}, 0);
    chk("R5 pc held", new_pc, pc0);
    fire(4'd10, 8'hC7, 64'h9990, 1'b0);
    chk("R5 fault fn6 unpriv", {63'd0, exc_fault}, 1);
    for (int c = 11; c < 16; c++) begin
      fire(4'(c), 8'h00, 64'h9990, 1'b0);
      chk("R10 fault bad code", {63'd0, exc_fault}, 1);
      chk("R10 new_pc held", new_pc, pc0);
      chk("R10 exc_addr held", exc_addr, a0);
      chk("R10 priv held", {63'd0, priv_mode}, 1);
      chk("R11 clear on fault", {63'd0, exc_clear}, 1);
    end
    @(negedge clk);
    chk("R11 idle clear low", {63'd0, exc_clear}, 0);
  endtask

  task automatic t_leave_reenter;
    leave_priv = 1'b1;
    @(negedge clk);
    leave_priv = 1'b0;
    chk("R12 leave clears", {63'd0, priv_mode}, 0);
    // fault while unprivileged must not change mode
    fire(4'd12, 8'h00, 64'h0, 1'b0);
    chk("R10 priv stays 0", {63'd0, priv_mode}, 0);
    fire(4'd3, 8'h00, 64'h4440, 1'b0);
    chk("R2 code3", new_pc, hbase + 64'h180);
    chk("R6 exc_addr bit0 clear", exc_addr, 64'h4440);
    chk("R8 second swap", {63'd0, swap_we}, 1);
    for (int i = 0; i < NREG; i++)
      chk("R8 shadow captured regs", swap_wdata[i*XLEN +: XLEN], init_val[i]);
    @(negedge clk);
    for (int i = 0; i < NREG; i++)
      chk("R8 regs restored", regs[i], init_val[i]);
    // leave together with exception: leave ignored
    fire(4'd1, 8'h00, 64'h5000, 1'b1);
    chk("R12 leave ignored", {63'd0, priv_mode}, 1);
    chk("R9 no swap when priv", {63'd0, swap_we}, 0);
    @(negedge clk);
    chk("R12 still priv", {63'd0, priv_mode}, 1);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      init_val[i] = 64'hA5A5_0000_0000_0000 + 64'(i * 'h111);
      regs[i] = init_val[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_entry();
    t_fixed();
    t_gate();
    t_faults();
    t_leave_reenter();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule